// File: doc/BRIEF.md
# Voted PLL and Branch Clock Gate Controller

This block lets software switch on clocks for a group of peripherals through a small 32-bit register bus. One register holds a request (vote) for a shared PLL. A stand-in model of the PLL reports lock a fixed number of register-clock cycles after the vote is raised, and drops lock as soon as the vote is withdrawn. A second vote register drives a request line for the peripheral-group bus clock. Each branch has its own control register. Its enable bit asks for the branch clock to be ungated, and a read-only off flag tells software when the gate has really opened.

Each branch gates either the PLL clock or the reference clock; a build-time mask picks which. The enable request crosses into the source domain through two flops. It is then taken on the falling source edge, so a gated output pulse is never cut short. The running state is captured on the next rising source edge and synchronised back through two flops before it reaches the off flag. Software can therefore set the enable and poll the off flag until it reads 0, knowing the clock is already toggling. A branch fed by the PLL stays gated until the PLL reports lock.

Top module: `clkgate_vote_ctrl`

## Requirements
- R1: After reset every branch reads enable 0 and off flag 1, the PLL vote, PLL status and group vote all read 0, `bus_clk_req` is 0 and no gated clock toggles.
- R2: A branch control register sits at 0x100 + 4*i. Bit 0 is the read/write enable and bit 31 is the read-only off flag. Writes to bit 31 and to every other bit are ignored, and all other bits read 0.
- R3: Once a branch is enabled and its source is available, its off flag reads 0. By the time it does, the gated clock has already made at least one rising edge.
- R4: Every high pulse on a gated clock lasts exactly one high phase of its source, including the pulses around enabling and disabling.
- R5: Clearing a branch enable stops its gated clock and returns its off flag to 1.
- R6: Bit 0 of the PLL vote register (0x000) requests the PLL. Status bit 17 of register 0x004 and `pll_active` rise exactly LOCK_CYCLES register-clock edges after the edge that stores the vote.
- R7: Writing the vote as 1 again while the PLL is already active has no effect, and the status stays 1.
- R8: Clearing the vote drops the PLL status on the next register-clock edge, and branches fed by the PLL then close and read off 1.
- R9: A PLL-fed branch that is enabled while the PLL is inactive stays gated: its off flag reads 1 and its clock does not toggle.
- R10: Bit 10 of the group vote register (0x008) is read/write and drives `bus_clk_req`. All other bits of that register read 0.
- R11: The PLL status register is read-only, and writes to it change neither the status nor the vote.
- R12: Read data appears on `rd_data` on the register-clock edge that samples `rd_en`, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-bus clock |
| rst | input | 1 | Synchronous active-high reset, also applied in each source domain |
| ref_clk | input | 1 | Reference source clock |
| pll_clk | input | 1 | PLL output clock |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| pll_active | output | 1 | PLL locked and running |
| bus_clk_req | output | 1 | Request for the peripheral-group bus clock |
| gclk | output | NUM_BRANCH | Gated branch clocks |

## Verification
The assertions assume that `wr_en` and `rd_en` are single-cycle strobes with a stable address and data in the clk domain. They also assume that reset is held long enough for every source clock to see it. The bench drives the bus only on falling edges of clk, keeps reset high for many cycles of the slowest source, and runs the source clocks free at unrelated periods. Random writes go only to the vote, status and unmapped registers, so the expected register state can be computed by the bench.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_PLL_VOTE = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_PLL_STAT = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_GRP_VOTE = 12'h008;
  localparam logic [3:0]        BR_PAGE      = 4'h1;   // branch registers at 0x1xx

  localparam int VOTE_BIT   = 0;
  localparam int STAT_BIT   = 17;
  localparam int GRP_BIT    = 10;
  localparam int BR_EN_BIT  = 0;
  localparam int BR_OFF_BIT = 31;
endpackage

// File: rtl/sync2.sv
module sync2 #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/pll_lock_model.sv
module pll_lock_model #(
  parameter int LOCK_CYCLES = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic vote_i,
  output logic active_o
);
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !vote_i) begin
      cnt_q    <= '0;
      active_o <= 1'b0;
    end else if (!active_o) begin
      if (cnt_q == LAST) active_o <= 1'b1;
      else               cnt_q    <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/branch_gate.sv
module branch_gate (
  input  logic clk,
  input  logic rst,
  input  logic src_clk,
  input  logic req_i,
  output logic gclk_o,
  output logic off_o
);
  logic req_s;
  logic open_q;
  logic run_q;

  // request into the source domain
  sync2 #(.RST_VAL(1'b0)) u_req_sync (
    .clk(src_clk), .rst(rst), .d(req_i), .q(req_s)
  );

  // gate changes only while the source is low
  always_ff @(negedge src_clk) begin
    if (rst) open_q <= 1'b0;
    else     open_q <= req_s;
  end

  // seen running at the rising edge that passed the first pulse
  always_ff @(posedge src_clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= open_q;
  end

  assign gclk_o = src_clk & open_q;

  sync2 #(.RST_VAL(1'b1)) u_off_sync (
    .clk(clk), .rst(rst), .d(~run_q), .q(off_o)
  );
endmodule

// File: rtl/clkgate_vote_ctrl.sv
module clkgate_vote_ctrl
  import clkgate_pkg::*;
#(
  parameter int NUM_BRANCH   = 3,
  parameter int LOCK_CYCLES  = 20,
  parameter logic [NUM_BRANCH-1:0] SRC_PLL_MASK = 3'b011
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ref_clk,
  input  logic                  pll_clk,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  pll_active,
  output logic                  bus_clk_req,
  output logic [NUM_BRANCH-1:0] gclk
);
  localparam int IDX_W = 6;

  logic                  vote_q;
  logic [NUM_BRANCH-1:0] br_en_q;
  logic [NUM_BRANCH-1:0] br_off;
  logic [NUM_BRANCH-1:0] br_hit;
  logic [DATA_W-1:0]     rd_mux;
  logic [IDX_W-1:0]      br_idx;
  logic                  br_page;

  assign br_idx  = addr[7:2];
  assign br_page = (addr[ADDR_W-1:8] == BR_PAGE) && (addr[1:0] == 2'b00);

  always_comb begin
    for (int i = 0; i < NUM_BRANCH; i++)
      br_hit[i] = br_page && (br_idx == IDX_W'(i));
  end

  // register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      vote_q      <= 1'b0;
      bus_clk_req <= 1'b0;
      br_en_q     <= '0;
    end else if (wr_en) begin
      if (addr == OFS_PLL_VOTE) vote_q      <= wr_data[VOTE_BIT];
      if (addr == OFS_GRP_VOTE) bus_clk_req <= wr_data[GRP_BIT];
      for (int i = 0; i < NUM_BRANCH; i++)
        if (br_hit[i]) br_en_q[i] <= wr_data[BR_EN_BIT];
    end
  end

  // read mux
  always_comb begin
    rd_mux = '0;
    if (addr == OFS_PLL_VOTE) rd_mux[VOTE_BIT] = vote_q;
    if (addr == OFS_PLL_STAT) rd_mux[STAT_BIT] = pll_active;
    if (addr == OFS_GRP_VOTE) rd_mux[GRP_BIT]  = bus_clk_req;
    for (int i = 0; i < NUM_BRANCH; i++) begin
      if (br_hit[i]) begin
        rd_mux[BR_EN_BIT]  = br_en_q[i];
        rd_mux[BR_OFF_BIT] = br_off[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  pll_lock_model #(.LOCK_CYCLES(LOCK_CYCLES)) u_pll (
    .clk(clk), .rst(rst), .vote_i(vote_q), .active_o(pll_active)
  );

  for (genvar g = 0; g < NUM_BRANCH; g++) begin : g_branch
    logic src;
    logic req;
    if (SRC_PLL_MASK[g]) begin : g_pll
      assign src = pll_clk;
      assign req = br_en_q[g] & pll_active;
    end else begin : g_ref
      assign src = ref_clk;
      assign req = br_en_q[g];
    end
    branch_gate u_gate (
      .clk(clk), .rst(rst), .src_clk(src), .req_i(req),
      .gclk_o(gclk[g]), .off_o(br_off[g])
    );
  end
endmodule

// File: rtl/clkgate_vote_ctrl_sva.sv
module clkgate_vote_ctrl_sva
  import clkgate_pkg::*;
#(
  parameter int NUM_BRANCH = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic [ADDR_W-1:0]     addr,
  input logic [DATA_W-1:0]     wr_data,
  input logic [DATA_W-1:0]     rd_data,
  input logic                  vote_q,
  input logic                  pll_active,
  input logic                  bus_clk_req,
  input logic [NUM_BRANCH-1:0] br_off
);
  assert_lock_needs_vote_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(pll_active) |-> vote_q);

  assert_active_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (pll_active && vote_q) |=> pll_active);

  assert_drop_on_unvote_R8: assert property (@(posedge clk) disable iff (rst)
    !vote_q |=> !pll_active);

  assert_group_vote_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_GRP_VOTE) |=> (bus_clk_req == $past(wr_data[GRP_BIT])));

  assert_status_read_R12: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFS_PLL_STAT) |=> (rd_data[STAT_BIT] == $past(pll_active)));

  assert_off_read_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == {4'h1, 8'h00}) |=> (rd_data[BR_OFF_BIT] == $past(br_off[0])));
endmodule

bind clkgate_vote_ctrl clkgate_vote_ctrl_sva #(.NUM_BRANCH(NUM_BRANCH)) u_sva (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wr_data(wr_data), .rd_data(rd_data), .vote_q(vote_q),
  .pll_active(pll_active), .bus_clk_req(bus_clk_req), .br_off(br_off)
);

// File: tb/clkgate_vote_ctrl_tb_top.sv
`timescale 1ns/1ps
module clkgate_vote_ctrl_tb_top;
  localparam int NB   = 3;
  localparam int LOCK = 20;
  localparam logic [2:0] MASK = 3'b011;
  localparam real REF_HALF = 5.0;
  localparam real PLL_HALF = 3.0;

  logic clk = 0, rst = 1, ref_clk = 0, pll_clk = 0;
  logic wr_en = 0, rd_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic pll_active, bus_clk_req;
  logic [NB-1:0] gclk;

  int errors = 0, checks = 0;
  int edges [NB];
  int runts [NB];
  real t_rise [NB];
  bit done = 0;

  always #2 clk = ~clk;
  always #(REF_HALF) ref_clk = ~ref_clk;
  initial begin
    #0.7;
    forever #(PLL_HALF) pll_clk = ~pll_clk;
  end

  clkgate_vote_ctrl #(.NUM_BRANCH(NB), .LOCK_CYCLES(LOCK), .SRC_PLL_MASK(MASK)) dut_i (
    .clk(clk), .rst(rst), .ref_clk(ref_clk), .pll_clk(pll_clk),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .pll_active(pll_active), .bus_clk_req(bus_clk_req), .gclk(gclk)
  );

  for (genvar g = 0; g < NB; g++) begin : g_mon
    always @(posedge gclk[g]) begin
      t_rise[g] = $realtime;
      edges[g]++;
    end
    always @(negedge gclk[g]) begin
      real w;
      w = $realtime - t_rise[g];
      if (w < (MASK[g] ? PLL_HALF : REF_HALF) - 0.01 ||
          w > (MASK[g] ? PLL_HALF : REF_HALF) + 0.01) runts[g]++;
    end
  end

  function automatic logic [11:0] br_addr(input int i);
    return 12'h100 + 12'(4 * i);
  endfunction

  function automatic logic [31:0] br_expect(input bit en, input bit off);
    return {off, 30'b0, en};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    d = rd_data;
  endtask

  // poll the off flag until it equals want; report edge count seen before that read
  task automatic poll_off(input int i, input bit want, output bit ok, output int seen);
    logic [31:0] d;
    ok = 0; seen = 0;
    for (int k = 0; k < 100 && !ok; k++) begin
      @(negedge clk);
      seen = edges[i];
      rd_en = 1; addr = br_addr(i);
      @(negedge clk);
      rd_en = 0;
      d = rd_data;
      if (d[31] == want) ok = 1;
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit ok;
    int seen, snap;
    bit grp_exp;
    void'($urandom(32'h5EED_0042));
    repeat (20) @(posedge clk);
    @(negedge clk) rst = 0;
    for (int i = 0; i < NB; i++) begin edges[i] = 0; runts[i] = 0; end

    // R1 reset state
    repeat (30) @(negedge clk);
    for (int i = 0; i < NB; i++) begin
      rd(br_addr(i), d);
      check("R1 branch reset", d, br_expect(0, 1));
    end
    rd(12'h000, d); check("R1 vote reset", d, 32'h0);
    rd(12'h004, d); check("R1 status reset", d, 32'h0);
    rd(12'h008, d); check("R1 group reset", d, 32'h0);
    check("R1 bus_clk_req", 32'(bus_clk_req), 32'h0);
    check("R1 no gated edges", 32'(edges[0] + edges[1] + edges[2]), 32'h0);

    // R10 R11 R12 random register traffic
    grp_exp = 0;
    for (int n = 0; n < 40; n++) begin
      logic [31:0] dat;
      int sel;
      dat = $urandom;
      sel = $urandom_range(0, 2);
      if (sel == 0) begin
        wr(12'h008, dat); grp_exp = dat[10];
        rd(12'h008, d); check("R10 group readback", d, {21'b0, grp_exp, 10'b0});
        check("R10 bus_clk_req", 32'(bus_clk_req), 32'(grp_exp));
      end else if (sel == 1) begin
        wr(12'h004, dat);
        rd(12'h004, d); check("R11 status ro", d, 32'h0);
        rd(12'h000, d); check("R11 vote untouched", d, 32'h0);
      end else begin
        logic [11:0] ua;
        ua = 12'h200 + 12'($urandom_range(0, 63) * 4);
        wr(ua, dat);
        rd(ua, d); check("R12 unmapped reads 0", d, 32'h0);
      end
    end

    // R9 PLL-fed branch without lock
    wr(br_addr(0), 32'h1);
    repeat (80) @(negedge clk);
    rd(br_addr(0), d); check("R9 off stays 1", d, br_expect(1, 1));
    check("R9 no edges", 32'(edges[0]), 32'h0);

    // R6 lock timing
    wr(12'h000, 32'h1);
    repeat (LOCK - 1) @(negedge clk);
    check("R6 not yet active", 32'(pll_active), 32'h0);
    @(negedge clk);
    check("R6 active after lock", 32'(pll_active), 32'h1);
    rd(12'h004, d); check("R6 status bit17", d, 32'h0002_0000);

    // R3 branch 0 now opens
    poll_off(0, 0, ok, seen);
    check("R3 branch0 off clears", 32'(ok), 32'h1);
    check("R3 branch0 ran before off=0", 32'(seen > 0), 32'h1);

    // R7 re-vote while active
    wr(12'h000, 32'h1);
    check("R7 still active", 32'(pll_active), 32'h1);
    repeat (5) @(negedge clk);
    check("R7 still active later", 32'(pll_active), 32'h1);

    // R3 ref-fed and second PLL-fed branch; R2 write to bit 31 ignored
    wr(br_addr(2), 32'hFFFF_FFFF);
    poll_off(2, 0, ok, seen);
    check("R3 branch2 off clears", 32'(ok), 32'h1);
    check("R3 branch2 ran before off=0", 32'(seen > 0), 32'h1);
    rd(br_addr(2), d); check("R2 branch2 readback", d, br_expect(1, 0));
    wr(br_addr(1), 32'h8000_0001);
    poll_off(1, 0, ok, seen);
    check("R3 branch1 off clears", 32'(ok), 32'h1);
    check("R3 branch1 ran before off=0", 32'(seen > 0), 32'h1);
    wr(br_addr(1), 32'h7FFF_FFFE);
    rd(br_addr(1), d); check("R2 enable cleared, other bits ignored", d[0], 32'h0);

    // R5 disable branch 2
    wr(br_addr(2), 32'h0);
    poll_off(2, 1, ok, seen);
    check("R5 branch2 off returns", 32'(ok), 32'h1);
    snap = edges[2];
    repeat (50) @(negedge clk);
    check("R5 branch2 stopped", 32'(edges[2]), 32'(snap));

    // random enable patterns with the PLL up
    for (int n = 0; n < 6; n++) begin
      logic [2:0] pat;
      pat = 3'($urandom);
      for (int i = 0; i < NB; i++) wr(br_addr(i), {31'b0, pat[i]});
      for (int i = 0; i < NB; i++) begin
        poll_off(i, !pat[i], ok, seen);
        check(pat[i] ? "R3 random enable" : "R5 random disable", 32'(ok), 32'h1);
      end
    end

    // R8 drop vote: status falls, PLL-fed branches close
    wr(br_addr(0), 32'h1);
    poll_off(0, 0, ok, seen);
    wr(12'h000, 32'h0);
    @(negedge clk);
    check("R8 status drops", 32'(pll_active), 32'h0);
    poll_off(0, 1, ok, seen);
    check("R8 branch0 closes", 32'(ok), 32'h1);
    snap = edges[0];
    repeat (50) @(negedge clk);
    check("R8 branch0 stopped", 32'(edges[0]), 32'(snap));

    // R4 no runt pulses anywhere
    for (int i = 0; i < NB; i++)
      check("R4 full-width pulses", 32'(runts[i]), 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule